// File: doc/BRIEF.md
# Three-Stream Sample Averager with Chroma Decimation

This block sits between three 8-bit sample streams and a downstream output formatter. One stream carries luma and two carry chroma. Every stream can leave the block as a straight copy after a fixed latency, or as the rounded mean of each adjacent pair of samples. For decimated output formats, the two chroma streams can instead be reduced to one rounded mean per block of four or eight consecutive samples. Each such result comes with a one-cycle strobe on that chroma bus.

A format-sync input sets where the chroma blocks start. The sync is pipelined together with the samples, so the input sample that shares a clock edge with the sync is always the first sample of a block. Between block results, each chroma output keeps its last result and its strobe stays low. The downstream formatter can therefore pick results off the strobe, or off its own cycle count taken from the same sync.

Top module: `triple_stream_averager`

## Requirements
- R1: With mode 2'b00, every output equals the input sample taken three clock edges earlier. If a sample is taken at edge k, it appears on the output right after edge k+3.
- R2: With mode 2'b01, every output equals the floor of half the sum of the samples taken at edges k-4 and k-3, shown right after edge k.
- R3: With mode 2'b10, each chroma result shown after edge k is the rounded mean of the four samples taken at edges k-6 through k-3.
- R4: With mode 2'b11, each chroma result shown after edge k is the rounded mean of the eight samples taken at edges k-10 through k-3.
- R5: A block mean with a fraction of exactly one half or less is rounded down. A fraction above one half is rounded up. The result for sum S over N samples is (S + N/2 - 1) / N, with integer division.
- R6: The luma stream has no block averaging. With mode 2'b10 or 2'b11 it behaves as in mode 2'b01.
- R7: A sync that is high at edge s makes the sample taken at edge s the first of a block. The first chroma strobe is then high right after edge s+N+2 (N = 4 or 8) and repeats every N edges. No two strobes are ever on consecutive cycles.
- R8: In the block modes, each chroma output holds its value while its strobe is low. In modes 2'b00 and 2'b01, both strobes are high on every cycle after the first edge that follows reset.
- R9: A synchronous active-high reset sets all outputs and both strobes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per stream per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 copy, 01 pair mean, 10 chroma 4-block, 11 chroma 8-block |
| fmt_sync | input | 1 | Marks the sample on this edge as first of a chroma block |
| y_in | input | 8 | Luma samples |
| cb_in | input | 8 | First chroma stream samples |
| cr_in | input | 8 | Second chroma stream samples |
| y_out | output | 8 | Luma result |
| cb_out | output | 8 | First chroma result |
| cr_out | output | 8 | Second chroma result |
| cb_vld | output | 1 | First chroma result strobe |
| cr_vld | output | 1 | Second chroma result strobe |

## Verification
The bench aims at the rounding boundary. It uses block sums whose fraction is exactly one half, one quarter and three quarters, plus full-scale blocks. A design that rounds half up, or that truncates, gives a result one code off on these blocks, and an accumulator that is too narrow wraps on the all-255 block.

It also sends syncs partway through a block. A design that misaligns the sync against the sample delay shows up as a strobe one edge early or late, or as a mean taken over a shifted window. A design that lets a partial block fire shows up as an extra strobe.

Luma is driven in the chroma-only modes to catch a luma lane that decimates. Each check that falls between strobes confirms the output has not moved.

// File: rtl/avg_types_pkg.sv
package avg_types_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_PAIR = 2'd1,
    MODE_QUAD = 2'd2,
    MODE_OCT  = 2'd3
  } avg_mode_e;
endpackage

// File: rtl/sample_taps.sv
// Shift register holding the last DEPTH samples; taps[j] is j+1 edges old.
module sample_taps #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else begin
      taps[0] <= din;
      for (int j = 1; j < DEPTH; j++) begin
        taps[j] <= taps[j-1];
      end
    end
  end
endmodule

// File: rtl/block_avg.sv
// Running-sum block averager over 2^(MAX_LOG-1) or 2^MAX_LOG samples.
module block_avg #(
  parameter int W       = 8,
  parameter int MAX_LOG = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sample,
  input  logic         start,
  input  logic         wide,
  output logic         fire,
  output logic [W-1:0] result
);
  localparam int ACC_W    = W + MAX_LOG;
  localparam int RND_WIDE = (1 << (MAX_LOG - 1)) - 1;
  localparam int RND_NAR  = (1 << (MAX_LOG - 2)) - 1;

  logic [MAX_LOG-1:0] ph;
  logic [MAX_LOG-1:0] last_mask;
  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   total;
  logic [ACC_W-1:0]   biased;

  always_comb begin
    total     = acc + ACC_W'(sample);
    last_mask = wide ? '1 : {1'b0, {(MAX_LOG-1){1'b1}}};
    fire      = !start && ((ph & last_mask) == last_mask);
    biased    = total + (wide ? ACC_W'(RND_WIDE) : ACC_W'(RND_NAR));
    result    = wide ? W'(biased >> MAX_LOG) : W'(biased >> (MAX_LOG - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      acc <= '0;
    end else if (start) begin
      ph  <= MAX_LOG'(1);
      acc <= ACC_W'(sample);
    end else begin
      ph  <= ph + 1'b1;
      acc <= fire ? '0 : total;
    end
  end
endmodule

// File: rtl/avg_lane.sv
// One stream: tap line, pair mean, optional block averager, output register.
module avg_lane
  import avg_types_pkg::*;
#(
  parameter int W        = 8,
  parameter bit BLOCK_EN = 1'b1,
  parameter int MAX_LOG  = 3,
  parameter int LATENCY  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] din,
  input  logic         sync_in,
  output logic [W-1:0] dout,
  output logic         dvld
);
  localparam int DEPTH    = LATENCY + 1;
  localparam int TAP_NEW  = LATENCY - 1;
  localparam int TAP_OLD  = LATENCY;

  avg_mode_e                  eff;
  logic [DEPTH-1:0][W-1:0]    taps;
  logic [W:0]                 psum;
  logic [W-1:0]               pair;
  logic                       blk_fire;
  logic [W-1:0]               blk_res;

  assign eff  = (!BLOCK_EN && mode[1]) ? MODE_PAIR : avg_mode_e'(mode);
  assign psum = {1'b0, taps[TAP_NEW]} + {1'b0, taps[TAP_OLD]};
  assign pair = psum[W:1];

  sample_taps #(.W(W), .DEPTH(DEPTH)) u_taps (
    .clk (clk),
    .rst (rst),
    .din (din),
    .taps(taps)
  );

  generate
    if (BLOCK_EN) begin : g_block
      logic [LATENCY-1:0] sync_pipe;
      always_ff @(posedge clk) begin
        if (rst) sync_pipe <= '0;
        else     sync_pipe <= {sync_pipe[LATENCY-2:0], sync_in};
      end
      block_avg #(.W(W), .MAX_LOG(MAX_LOG)) u_blk (
        .clk   (clk),
        .rst   (rst),
        .sample(taps[TAP_NEW]),
        .start (sync_pipe[LATENCY-1]),
        .wide  (eff == MODE_OCT),
        .fire  (blk_fire),
        .result(blk_res)
      );
    end else begin : g_noblock
      logic sync_unused;
      assign sync_unused = sync_in;
      assign blk_fire    = 1'b0;
      assign blk_res     = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      dvld <= 1'b0;
    end else begin
      case (eff)
        MODE_PASS: begin
          dout <= taps[TAP_NEW];
          dvld <= 1'b1;
        end
        MODE_PAIR: begin
          dout <= pair;
          dvld <= 1'b1;
        end
        default: begin
          if (blk_fire) dout <= blk_res;
          dvld <= blk_fire;
        end
      endcase
    end
  end

  // cycles since reset, saturating; used only by the assertions below
  logic [2:0] chk_age;
  always_ff @(posedge clk) begin
    if (rst)               chk_age <= '0;
    else if (chk_age != '1) chk_age <= chk_age + 1'b1;
  end

  AST_PASS_DELAY: assert property (@(posedge clk) disable iff (rst)
    (chk_age >= 3'd6 && $past(eff) == MODE_PASS) |-> dout == $past(din, 4)); // R1

  AST_PAIR_BOUND: assert property (@(posedge clk) disable iff (rst)
    (chk_age >= 3'd6 && $past(eff) == MODE_PAIR) |->
      ((dout >= $past(din, 4)) || (dout >= $past(din, 5))) &&
      ((dout <= $past(din, 4)) || (dout <= $past(din, 5)))); // R2

  generate
    if (BLOCK_EN) begin : g_blk_chk
      AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (chk_age >= 3'd3 && $past(dvld) && $past(eff) >= MODE_QUAD &&
         $past(eff, 2) >= MODE_QUAD) |-> !dvld); // R7

      AST_HOLD_OFF_PHASE: assert property (@(posedge clk) disable iff (rst)
        (chk_age >= 3'd2 && $past(eff) >= MODE_QUAD && !dvld) |-> $stable(dout)); // R8
    end
  endgenerate
endmodule

// File: rtl/triple_stream_averager.sv
module triple_stream_averager #(
  parameter int W       = 8,
  parameter int MAX_LOG = 3,
  parameter int LATENCY = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         fmt_sync,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] cb_in,
  input  logic [W-1:0] cr_in,
  output logic [W-1:0] y_out,
  output logic [W-1:0] cb_out,
  output logic [W-1:0] cr_out,
  output logic         cb_vld,
  output logic         cr_vld
);
  localparam int NCHROMA = 2;

  logic [NCHROMA-1:0][W-1:0] c_in;
  logic [NCHROMA-1:0][W-1:0] c_out;
  logic [NCHROMA-1:0]        c_vld;
  logic                      y_vld_unused;

  assign c_in[0] = cb_in;
  assign c_in[1] = cr_in;
  assign cb_out  = c_out[0];
  assign cr_out  = c_out[1];
  assign cb_vld  = c_vld[0];
  assign cr_vld  = c_vld[1];

  avg_lane #(.W(W), .BLOCK_EN(1'b0), .MAX_LOG(MAX_LOG), .LATENCY(LATENCY)) u_luma (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .din    (y_in),
    .sync_in(fmt_sync),
    .dout   (y_out),
    .dvld   (y_vld_unused)
  );

  generate
    for (genvar i = 0; i < NCHROMA; i++) begin : g_chroma
      avg_lane #(.W(W), .BLOCK_EN(1'b1), .MAX_LOG(MAX_LOG), .LATENCY(LATENCY)) u_chroma (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .din    (c_in[i]),
        .sync_in(fmt_sync),
        .dout   (c_out[i]),
        .dvld   (c_vld[i])
      );
    end
  endgenerate
endmodule

// File: tb/triple_stream_averager_tb.sv
module triple_stream_averager_tb;
  localparam int CLK_NS = 10;
  localparam int HIST   = 8192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       fmt_sync = 1'b0;
  logic [7:0] y_in = '0, cb_in = '0, cr_in = '0;
  logic [7:0] y_out, cb_out, cr_out;
  logic       cb_vld, cr_vld;

  int hy [0:HIST-1];
  int hc [0:1][0:HIST-1];
  int hm [0:HIST-1];
  bit hs [0:HIST-1];
  int ec = 16;
  int seg_start = 16;
  int prev_c [0:1];
  int total = 0, bad = 0;
  string tag_over = "";

  always #(CLK_NS/2) clk = ~clk;

  triple_stream_averager u_dut (
    .clk(clk), .rst(rst), .mode(mode), .fmt_sync(fmt_sync),
    .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
    .cb_vld(cb_vld), .cr_vld(cr_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (edge %0d)", tag, act, exp, ec);
    end
  endtask

  function automatic int rnd_mean(input int s, input int n);
    return (s + n/2 - 1) / n;
  endfunction

  function automatic int eff_sync(input int e);
    for (int i = e - 3; i >= seg_start; i--) if (hs[i]) return i;
    return -1;
  endfunction

  task automatic check_edge(input int e);
    int m, ey, act, av, n, s, d, sum;
    string t;
    m  = hm[e];
    ey = (m == 0) ? hy[e-3] : (hy[e-3] + hy[e-4]) / 2;
    t  = (m == 0) ? "R1" : (m == 1) ? "R2" : "R6";
    chk(int'(y_out) == ey, t, int'(y_out), ey);
    for (int c = 0; c < 2; c++) begin
      act = (c == 0) ? int'(cb_out) : int'(cr_out);
      av  = (c == 0) ? int'(cb_vld) : int'(cr_vld);
      if (m < 2) begin
        ey = (m == 0) ? hc[c][e-3] : (hc[c][e-3] + hc[c][e-4]) / 2;
        chk(act == ey, (m == 0) ? "R1" : "R2", act, ey);
        chk(av == 1, "R8", av, 1);
      end else begin
        n = (m == 2) ? 4 : 8;
        s = eff_sync(e);
        if (s >= 0) begin
          d = e - s - n - 2;
          if (d >= 0 && d % n == 0) begin
            sum = 0;
            for (int j = e - 3 - n + 1; j <= e - 3; j++) sum += hc[c][j];
            ey = rnd_mean(sum, n);
            chk(av == 1, "R7", av, 1);
            chk(act == ey, (tag_over != "") ? tag_over : ((n == 4) ? "R3" : "R4"), act, ey);
          end else begin
            chk(av == 0, "R7", av, 0);
            chk(act == prev_c[c], "R8", act, prev_c[c]);
          end
        end
      end
      prev_c[c] = act;
    end
  endtask

  task automatic cyc(input int y, input int b, input int r, input bit s);
    y_in = 8'(y); cb_in = 8'(b); cr_in = 8'(r); fmt_sync = s;
    @(posedge clk);
    hy[ec] = y; hc[0][ec] = b; hc[1][ec] = r; hm[ec] = int'(mode); hs[ec] = s;
    @(negedge clk);
    check_edge(ec);
    ec++;
  endtask

  task automatic set_mode(input int m);
    mode = 2'(m);
    seg_start = ec;
  endtask

  task automatic rand_run(input int cycles, input int sync_every);
    for (int i = 0; i < cycles; i++) begin
      bit s;
      s = (sync_every > 0) && ($urandom % sync_every == 0);
      cyc($urandom % 256, $urandom % 256, $urandom % 256, s);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int q4 [16] = '{0,0,0,2, 0,0,1,2, 255,255,255,254, 1,0,0,0};
    int q8 [32] = '{0,0,0,0,0,0,6,6, 7,6,0,0,0,0,0,0,
                    255,255,255,255,255,255,255,255, 4,0,0,0,0,0,0,0};
    seed = $urandom(32'd4242);
    for (int i = 0; i < HIST; i++) begin
      hy[i] = 0; hc[0][i] = 0; hc[1][i] = 0; hm[i] = 0; hs[i] = 0;
    end
    prev_c[0] = 0; prev_c[1] = 0;

    // R9: reset state with busy inputs
    y_in = 8'hA5; cb_in = 8'h5A; cr_in = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(y_out == 0 && cb_out == 0 && cr_out == 0, "R9", int'(y_out | cb_out | cr_out), 0);
    chk(cb_vld == 0 && cr_vld == 0, "R9", int'(cb_vld | cr_vld), 0);
    y_in = 0; cb_in = 0; cr_in = 0;
    rst = 1'b0;

    set_mode(0); rand_run(200, 0);
    set_mode(1); rand_run(200, 0);
    set_mode(2); cyc(1, 2, 3, 1'b1); rand_run(300, 0); rand_run(300, 37);
    set_mode(3); cyc(9, 8, 7, 1'b1); rand_run(300, 0); rand_run(300, 53);

    // R5: rounding boundaries, 4-sample blocks
    set_mode(2);
    tag_over = "R5";
    for (int i = 0; i < 16; i++) cyc($urandom % 256, q4[i], q4[15 - i], (i == 0));
    rand_run(12, 0);
    // R5: rounding boundaries, 8-sample blocks
    set_mode(3);
    for (int i = 0; i < 32; i++) cyc($urandom % 256, q8[i], q8[31 - i], (i == 0));
    rand_run(16, 0);
    tag_over = "";

    // back to pair mode after block modes (R2, R8)
    set_mode(1); rand_run(50, 5);

    // R9: reset in mid-run
    @(negedge clk);
    rst = 1'b1; y_in = 8'h77; cb_in = 8'h33; cr_in = 8'hCC;
    @(posedge clk);
    @(negedge clk);
    chk(y_out == 0 && cb_out == 0 && cr_out == 0, "R9", int'(y_out | cb_out | cr_out), 0);
    chk(cb_vld == 0 && cr_vld == 0, "R9", int'(cb_vld | cr_vld), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule